// File: doc/BRIEF.md
# Presettable Binary Down Counter

This block is a binary down counter (8 bits by default) whose controls are all active-low. On each rising clock edge it either loads a preset word, steps down by one, or keeps its value. The choice depends on a synchronous load input and a carry-in/count-enable input. Two further controls act at once, with no clock edge. The first, an asynchronous clear, forces the count to all ones. The second, an asynchronous force, copies the preset word into the count. While the force input stays low, the count keeps following the preset word.

The single terminal-count output is active-low. It is low while the count is zero and the carry-in is low, so it lasts one full clock period during normal counting. To build a longer down counter, feed one stage's terminal-count output into the next stage's carry-in and run every stage from the same clock. The upper stage then steps only in the cycle where all lower stages read zero. The count value is also brought out so that the enclosing logic can read it.

Top module: `preset_down_counter`

## Requirements
- R1: While `clear_n` is low, `count_q` equals all ones (255 at the default width), at once and with no clock edge, whatever the other inputs do.
- R2: While `clear_n` is high and `force_n` is low, `count_q` equals `jam_word` at once and keeps tracking it, whatever `load_n`, `cin_n` and the clock do.
- R3: With both asynchronous controls high and `load_n` low, a rising clock edge loads `jam_word` into `count_q`, whatever `cin_n` is; nothing is loaded before that edge.
- R4: With both asynchronous controls high, `load_n` high and `cin_n` low, each rising clock edge lowers `count_q` by one.
- R5: With both asynchronous controls high, `load_n` high and `cin_n` high, `count_q` does not change across clock edges.
- R6: A counting edge taken while `count_q` is zero leaves `count_q` at all ones.
- R7: `tc_n` is low exactly when `count_q` is zero and `cin_n` is low. It follows both of them combinationally, so during counting it is low for one clock period.
- R8: Two instances can be chained: the lower stage's `tc_n` drives the upper stage's `cin_n`, and both share one clock and one load input. The pair then acts as a 16-bit down counter whose upper `tc_n` is low only at a combined value of zero. It holds while the lower `cin_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear to all ones, active-low, highest priority |
| force_n | input | 1 | Asynchronous preset from `jam_word`, active-low |
| load_n | input | 1 | Synchronous preset from `jam_word`, active-low |
| cin_n | input | 1 | Carry-in / count enable, active-low |
| jam_word | input | WIDTH | Preset word |
| count_q | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count (zero and enabled), active-low |

## Verification
The hardest states to reach are the ones where a zero count and a rising carry-in meet across a chained pair, because the upper stage moves only once every 256 lower-stage steps. The bench presets the chained pair just above a 256-boundary and then counts it down across two such boundaries and through the combined zero. This covers the combined wrap and the single-period carry-out. The asynchronous paths also need care. The bench asserts them between clock edges, holds them across an edge, and changes the preset word while the force is held. This shows that they act with no clock and that the level is followed. The bench also runs every one of the sixteen control combinations from a known count.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

   // Clocked action chosen when no asynchronous control is active.
   typedef enum logic [1:0] {
      PDC_HOLD  = 2'd0,
      PDC_COUNT = 2'd1,
      PDC_LOAD  = 2'd2
   } pdc_op_e;

   // Synchronous load dominates counting; counting dominates holding.
   function automatic pdc_op_e pdc_pick_op(input logic load_n, input logic cin_n);
      if (!load_n)     return PDC_LOAD;
      else if (!cin_n) return PDC_COUNT;
      else             return PDC_HOLD;
   endfunction

endpackage

// File: rtl/pdc_next.sv
module pdc_next #(
   parameter int WIDTH = 8
) (
   input  logic             load_n,
   input  logic             cin_n,
   input  logic [WIDTH-1:0] jam_word,
   input  logic [WIDTH-1:0] count_cur,
   output logic [WIDTH-1:0] count_nxt
);
   import pdc_pkg::*;

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   pdc_op_e op;

   always_comb begin
      op = pdc_pick_op(load_n, cin_n);
      unique case (op)
         PDC_LOAD:  count_nxt = jam_word;
         PDC_COUNT: count_nxt = count_cur - ONE;
         default:   count_nxt = count_cur;
      endcase
   end
endmodule

// File: rtl/pdc_cell.sv
module pdc_cell (
   input  logic clk,
   input  logic set_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   // Storage bit with asynchronous set and reset; reset wins if both rise.
   always_ff @(posedge clk or posedge rst_i or posedge set_i) begin
      if (rst_i)      q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else            q_o <= d_i;
   end
endmodule

// File: rtl/pdc_zero.sv
module pdc_zero #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] count_i,
   input  logic             cin_n,
   output logic             tc_n
);
   logic at_zero;

   always_comb begin
      at_zero = ~|count_i;
      tc_n    = ~(at_zero & ~cin_n);
   end
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter #(
   parameter int WIDTH       = 8,
   // 1: per-bit set/reset storage, so a held force follows jam_word.
   // 0: word register loading jam_word on the force's falling edge and on clocks while held.
   parameter bit LEVEL_FORCE = 1'b1
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             force_n,
   input  logic             load_n,
   input  logic             cin_n,
   input  logic [WIDTH-1:0] jam_word,
   output logic [WIDTH-1:0] count_q,
   output logic             tc_n
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   if (WIDTH < 2 || WIDTH > 64) begin : g_width_bad
      $error("preset_down_counter: WIDTH must be within 2..64");
   end

   logic [WIDTH-1:0] count_nxt;

   pdc_next #(.WIDTH(WIDTH)) u_next (
      .load_n    (load_n),
      .cin_n     (cin_n),
      .jam_word  (jam_word),
      .count_cur (count_q),
      .count_nxt (count_nxt)
   );

   if (LEVEL_FORCE) begin : g_level
      logic [WIDTH-1:0] bit_set;
      logic [WIDTH-1:0] bit_rst;
      // Clear drives every bit's set; force steers each bit by its jam bit.
      always_comb begin
         bit_set = {WIDTH{~clear_n}} | ({WIDTH{~force_n}} & jam_word);
         bit_rst = {WIDTH{clear_n & ~force_n}} & ~jam_word;
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         pdc_cell u_cell (
            .clk   (clk),
            .set_i (bit_set[i]),
            .rst_i (bit_rst[i]),
            .d_i   (count_nxt[i]),
            .q_o   (count_q[i])
         );
      end
   end else begin : g_edge
      logic [WIDTH-1:0] word_q;
      always_ff @(posedge clk or negedge clear_n or negedge force_n) begin
         if (!clear_n)      word_q <= ALL_ONES;
         else if (!force_n) word_q <= jam_word;
         else               word_q <= count_nxt;
      end
      assign count_q = word_q;
   end

   pdc_zero #(.WIDTH(WIDTH)) u_zero (
      .count_i (count_q),
      .cin_n   (cin_n),
      .tc_n    (tc_n)
   );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             clear_n,
   input logic             force_n,
   input logic             load_n,
   input logic             cin_n,
   input logic [WIDTH-1:0] jam_word,
   input logic [WIDTH-1:0] count_q,
   input logic             tc_n
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

   // R1
   clear_ones_chk: assert property (@(posedge clk)
      !clear_n |-> count_q == ALL_ONES);

   // R2
   force_tracks_chk: assert property (@(posedge clk) disable iff (!clear_n)
      !force_n |-> count_q == jam_word);

   // R3
   sync_load_chk: assert property (@(posedge clk) disable iff (!clear_n || !force_n)
      !load_n |=> count_q == $past(jam_word));

   // R4
   step_down_chk: assert property (@(posedge clk) disable iff (!clear_n || !force_n)
      (load_n && !cin_n) |=> count_q == WIDTH'($past(count_q) - ONE));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!clear_n || !force_n)
      (load_n && cin_n) |=> $stable(count_q));

   // R6
   wrap_ones_chk: assert property (@(posedge clk) disable iff (!clear_n || !force_n)
      (load_n && !cin_n && count_q == '0) |=> count_q == ALL_ONES);

   // R7
   tc_only_at_zero_chk: assert property (@(posedge clk) disable iff (!clear_n)
      !tc_n |-> count_q == '0);

   // R7
   tc_gated_chk: assert property (@(posedge clk) disable iff (!clear_n)
      cin_n |-> tc_n);
endmodule

bind preset_down_counter pdc_checker #(.WIDTH(WIDTH)) u_pdc_chk (
   .clk      (clk),
   .clear_n  (clear_n),
   .force_n  (force_n),
   .load_n   (load_n),
   .cin_n    (cin_n),
   .jam_word (jam_word),
   .count_q  (count_q),
   .tc_n     (tc_n)
);

// File: tb/preset_down_counter_test.sv
`timescale 1ns/1ps
module preset_down_counter_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       clear_n = 1'b1, force_n = 1'b1, load_n = 1'b1, cin_n = 1'b1;
   logic [7:0] jam = 8'h00;
   logic [7:0] count_q;
   logic       tc_n;

   logic        c_clear_n = 1'b1, c_load_n = 1'b1, c_cin_n = 1'b1;
   logic [15:0] c_jam = 16'h0000;
   logic [7:0]  lo_q, hi_q;
   logic        lo_tc_n, hi_tc_n;

   int  n_cmp = 0, n_bad = 0;
   bit  done = 1'b0;

   preset_down_counter uut (
      .clk(clk), .clear_n(clear_n), .force_n(force_n), .load_n(load_n),
      .cin_n(cin_n), .jam_word(jam), .count_q(count_q), .tc_n(tc_n));

   preset_down_counter casc_lo (
      .clk(clk), .clear_n(c_clear_n), .force_n(1'b1), .load_n(c_load_n),
      .cin_n(c_cin_n), .jam_word(c_jam[7:0]), .count_q(lo_q), .tc_n(lo_tc_n));

   preset_down_counter casc_hi (
      .clk(clk), .clear_n(c_clear_n), .force_n(1'b1), .load_n(c_load_n),
      .cin_n(lo_tc_n), .jam_word(c_jam[15:8]), .count_q(hi_q), .tc_n(hi_tc_n));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic edge_sample();
      @(posedge clk);
      #2;
   endtask

   initial begin
      #1_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int e;
      int e16;
      logic [7:0] prev;
      logic [7:0] exp_now, exp_edge;

      // R1: asynchronous clear before any clock edge
      #2;
      clear_n   = 1'b0;
      c_clear_n = 1'b0;
      #1;
      check("R1 clear without clock", count_q, 255);
      check("R7 tc high at clear", tc_n, 1);

      // R1: clear overrides every other control across an edge
      @(negedge clk);
      force_n = 1'b0; load_n = 1'b0; cin_n = 1'b0; jam = 8'h3C;
      #1;
      check("R1 clear beats force", count_q, 255);
      edge_sample();
      check("R1 clear beats clocked paths", count_q, 255);

      // R2: release clear while force held
      @(negedge clk);
      clear_n = 1'b1; c_clear_n = 1'b1;
      #1;
      check("R2 force after clear release", count_q, 8'h3C);
      jam = 8'hC3;
      #1;
      check("R2 force follows jam", count_q, 8'hC3);
      edge_sample();
      check("R2 force beats clock", count_q, 8'hC3);
      @(negedge clk);
      force_n = 1'b1; load_n = 1'b1; cin_n = 1'b0;
      #1;
      check("R2 value kept after release", count_q, 8'hC3);
      edge_sample();
      check("R4 step after force", count_q, 8'hC2);

      // R3: every preset value, carry-in alternating
      prev = 8'hC2;
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         jam = 8'(v); load_n = 1'b0; cin_n = v[0];
         #1;
         check("R3 no load before edge", count_q, prev);
         edge_sample();
         check("R3 sync load", count_q, v);
         check("R7 tc after load", tc_n, (v == 0 && v[0] == 1'b0) ? 0 : 1);
         prev = 8'(v);
      end

      // R4 R6 R7: count down 300 steps from 255, crossing zero once
      @(negedge clk);
      load_n = 1'b1; cin_n = 1'b0;
      e = 255;
      for (int k = 0; k < 300; k++) begin
         edge_sample();
         e = (e - 1) & 255;
         check("R4 decrement", count_q, e);
         check("R7 tc during count", tc_n, (e == 0) ? 0 : 1);
      end

      // R6: wrap from zero
      @(negedge clk);
      jam = 8'h00; load_n = 1'b0; cin_n = 1'b1;
      edge_sample();
      check("R7 tc gated by carry-in", tc_n, 1);
      @(negedge clk);
      load_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         edge_sample();
         check("R5 hold at zero", count_q, 0);
      end
      @(negedge clk);
      cin_n = 1'b0;
      #1;
      check("R7 tc falls without clock", tc_n, 0);
      edge_sample();
      check("R6 wrap to all ones", count_q, 255);
      check("R7 tc rises after wrap", tc_n, 1);

      // R5: hold at a nonzero value
      @(negedge clk);
      cin_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         edge_sample();
         check("R5 hold", count_q, 255);
      end

      // R1 R2 R3 R4 R5: all sixteen control combinations from 0x40
      for (int c = 0; c < 16; c++) begin
         @(negedge clk);
         clear_n = 1'b1; force_n = 1'b1; load_n = 1'b0; cin_n = 1'b1; jam = 8'h40;
         edge_sample();
         check("R3 combo setup", count_q, 8'h40);
         @(negedge clk);
         clear_n = c[3]; force_n = c[2]; load_n = c[1]; cin_n = c[0]; jam = 8'hA5;
         exp_now  = !c[3] ? 8'hFF : (!c[2] ? 8'hA5 : 8'h40);
         exp_edge = !c[3] ? 8'hFF : (!c[2] ? 8'hA5 : (!c[1] ? 8'hA5 : (!c[0] ? 8'h3F : 8'h40)));
         #1;
         check("R1 R2 combo before edge", count_q, exp_now);
         edge_sample();
         check("R3 R4 R5 combo after edge", count_q, exp_edge);
         check("R7 combo tc", tc_n, 1);
      end
      @(negedge clk);
      clear_n = 1'b1; force_n = 1'b1; load_n = 1'b1; cin_n = 1'b1;

      // R8: chained pair preset to 0x0203, counted through zero
      @(negedge clk);
      c_jam = 16'h0203; c_load_n = 1'b0; c_cin_n = 1'b1;
      edge_sample();
      check("R8 chained load", {hi_q, lo_q}, 16'h0203);
      @(negedge clk);
      c_load_n = 1'b1; c_cin_n = 1'b0;
      e16 = 16'h0203;
      for (int k = 0; k < 600; k++) begin
         edge_sample();
         e16 = (e16 - 1) & 16'hFFFF;
         check("R8 chained count", {hi_q, lo_q}, e16);
         check("R8 chained carry-out", hi_tc_n, (e16 == 0) ? 0 : 1);
      end
      @(negedge clk);
      c_cin_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         edge_sample();
         check("R8 chained hold", {hi_q, lo_q}, e16);
      end

      finish_run();
   end
endmodule